// File: doc/BRIEF.md
# Hotspot-Triggered Bus Trace Capture

This block sits on a cartridge-side address/data bus and records every bus cycle in a rolling history. Test firmware running on the host processor checks its own memory writes. When a write does not read back correctly, the firmware touches a reserved "hotspot" address that normal code never uses. The block watches for these addresses. On a hit it records a few more cycles and then freezes the history, so that the bus activity leading up to the failure can be read out afterwards.

Hotspots come in pairs, one pair per test category. The even address of a pair carries the data value that failed to verify. The odd address right after it carries the index of the RAM cell that failed. The block latches the category and the value from the hit that triggers it. It takes the index from the first later odd access of the same category. While it is triggered it also counts further error reports per category. A clear input re-arms the capture.

The control is a three-state machine. **ARMED** records and watches for a trigger. **POST** records a fixed number of further cycles. **FROZEN** holds the trace. The transitions are:
- *trigger*: ARMED → POST, on a strobed even-hotspot access.
- *window done*: POST → FROZEN, on the last post-trigger strobe.
- *rearm*: any state → ARMED, when clear is high.

Top module: `hotspot_trace_capture`

## Requirements
- R1: After reset the following are all low or zero: `triggered`, `frozen`, `err_index_valid`, every error counter, and every `rd_valid`.
- R2: Each strobed cycle recorded while not FROZEN stores three things: the address, the data, and a cycle number. The cycle number counts strobes since reset, so the first strobe gets 0. Readout index 0 is the oldest slot and DEPTH-1 is the newest.
- R3: The value hotspot of category c (c = 0..4) is at BASE + 16·c, and its index hotspot is at BASE + 16·c + 1. BASE defaults to 0x800. The categories, in order, are:
  - 0: indexed write/read with ghost accesses
  - 1: pointer-indexed write/read with ghost accesses
  - 2: plain indexed write/read
  - 3: pointer-indexed write/read
  - 4: absolute write/read
- R4: A strobed access to a value hotspot while ARMED sets `triggered`, sets `err_cat` to c, and sets `err_value` to the bus data. These stay held until clear.
- R5: After the trigger cycle exactly POST further strobes are recorded, and then `frozen` rises. The trigger cycle appears at readout index DEPTH-1-POST. A frozen trace does not change on later strobes.
- R6: After the trigger, the first strobed index-hotspot access of the same category latches the bus data into `err_index` and sets `err_index_valid`. Index accesses of other categories are ignored. Later index accesses are also ignored.
- R7: The following never trigger and never latch an index: any address other than the five value hotspots, and index-hotspot accesses made while ARMED.
- R8: While triggered, each strobed value-hotspot access of category c adds one to counter c. The trigger access itself is not counted. Counters saturate at their maximum.
- R9: Clear returns the block to ARMED. It invalidates all trace slots and zeroes the records and the counters. The cycle number keeps counting.
- R10: A cycle with `bus_strobe` low has no effect, even when the address is a hotspot.
- R11: A slot not written since the last clear or reset reads with `rd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Re-arm capture, drop trace and records |
| bus_strobe | input | 1 | One pulse per bus cycle |
| bus_addr | input | ADDR_W | Cartridge-relative bus address |
| bus_data | input | DATA_W | Bus data |
| rd_idx | input | log2(DEPTH) | Readout slot, 0 = oldest |
| rd_addr | output | ADDR_W | Address stored in the slot |
| rd_data | output | DATA_W | Data stored in the slot |
| rd_cycle | output | CYC_W | Cycle number stored in the slot |
| rd_valid | output | 1 | Slot was written since arming |
| triggered | output | 1 | State is POST or FROZEN |
| frozen | output | 1 | State is FROZEN |
| err_cat | output | 3 | Category of the trigger |
| err_value | output | DATA_W | Value reported at trigger |
| err_index | output | DATA_W | Reported failing RAM index |
| err_index_valid | output | 1 | `err_index` has been latched |
| err_counts | output | 5·CNT_W | Per-category counters, c at [c·CNT_W +: CNT_W] |

## Verification
The bench sweeps every address of the space while the block is armed. This finds a decoder that fires on an index hotspot, on a neighbour inside a pair block, or on a sixth category slot, because such a design would raise `triggered` early.

For each category it varies how many cycles come before the trigger. It then rebuilds the expected frozen window from its own log. An off-by-one post window, a wrong oldest-slot pointer, or stale slots reported valid would show up as misplaced entries.

It also sends index reports of a foreign category and duplicate index reports, and it holds a hotspot address on the bus with the strobe low. A design that latches too eagerly would show the wrong `err_index`.

Finally it over-drives one counter past saturation. A counter that wraps would read near zero.

// File: rtl/hs_pkg.sv
package hs_pkg;
    localparam int CAT_NUM    = 5;
    localparam int CAT_W      = 3;
    localparam int CAT_STRIDE = 16;

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_POST   = 2'd1,
        ST_FROZEN = 2'd2
    } cap_state_e;
endpackage

// File: rtl/hs_decoder.sv
module hs_decoder
    import hs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BASE   = 'h800
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              even_hit,
    output logic              odd_hit,
    output logic [CAT_W-1:0]  cat
);
    logic [CAT_NUM-1:0] ev_match;
    logic [CAT_NUM-1:0] od_match;

    for (genvar c = 0; c < CAT_NUM; c++) begin : g_cat
        assign ev_match[c] = (addr == ADDR_W'(BASE + c * CAT_STRIDE));
        assign od_match[c] = (addr == ADDR_W'(BASE + c * CAT_STRIDE + 1));
    end

    always_comb begin
        even_hit = |ev_match;
        odd_hit  = |od_match;
        cat      = '0;
        for (int c = 0; c < CAT_NUM; c++) begin
            if (ev_match[c] || od_match[c]) cat = CAT_W'(c);
        end
    end
endmodule

// File: rtl/hs_ring.sv
module hs_ring #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int CYC_W  = 16,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CYC_W-1:0]  wr_cyc,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CYC_W-1:0]  rd_cyc,
    output logic              rd_valid
);
    logic [ADDR_W-1:0] mem_addr [DEPTH];
    logic [DATA_W-1:0] mem_data [DEPTH];
    logic [CYC_W-1:0]  mem_cyc  [DEPTH];
    logic [DEPTH-1:0]  slot_ok;
    logic [PTR_W-1:0]  wp;
    logic [PTR_W-1:0]  phys;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp      <= '0;
            slot_ok <= '0;
        end else if (wr_en) begin
            wp          <= wp + 1'b1;
            slot_ok[wp] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_addr[wp] <= wr_addr;
            mem_data[wp] <= wr_data;
            mem_cyc[wp]  <= wr_cyc;
        end
    end

    // write pointer marks the oldest slot once the ring has wrapped
    assign phys     = wp + rd_idx;
    assign rd_addr  = mem_addr[phys];
    assign rd_data  = mem_data[phys];
    assign rd_cyc   = mem_cyc[phys];
    assign rd_valid = slot_ok[phys];

    AST_RING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !flush) |=> ($stable(wp) && $stable(slot_ok)))
        else $error("ring moved without write"); // R5
endmodule

// File: rtl/hs_records.sv
module hs_records
    import hs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     strobe,
    input  logic                     armed,
    input  logic                     trig,
    input  logic                     even_hit,
    input  logic                     odd_hit,
    input  logic [CAT_W-1:0]         hit_cat,
    input  logic [DATA_W-1:0]        data,
    output logic [CAT_W-1:0]         cat_q,
    output logic [DATA_W-1:0]        value_q,
    output logic [DATA_W-1:0]        index_q,
    output logic                     index_ok,
    output logic [CAT_NUM*CNT_W-1:0] counts
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic take_idx;
    assign take_idx = strobe && !armed && odd_hit && !index_ok && (hit_cat == cat_q);

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cat_q    <= '0;
            value_q  <= '0;
            index_q  <= '0;
            index_ok <= 1'b0;
        end else if (trig) begin
            cat_q    <= hit_cat;
            value_q  <= data;
            index_ok <= 1'b0;
        end else if (take_idx) begin
            index_q  <= data;
            index_ok <= 1'b1;
        end
    end

    for (genvar c = 0; c < CAT_NUM; c++) begin : g_cnt
        logic [CNT_W-1:0] cnt;
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                cnt <= '0;
            end else if (strobe && !armed && even_hit &&
                         hit_cat == CAT_W'(c) && cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
        assign counts[c*CNT_W +: CNT_W] = cnt;

        AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            !flush |=> (cnt >= $past(cnt)))
            else $error("counter decreased"); // R8
    end

    AST_INDEX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (index_ok && !flush && !trig) |=> (index_ok && $stable(index_q)))
        else $error("index changed after latch"); // R6
endmodule

// File: rtl/hotspot_trace_capture.sv
module hotspot_trace_capture
    import hs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int CYC_W  = 16,
    parameter int DEPTH  = 16,
    parameter int POST   = 4,
    parameter int CNT_W  = 8,
    parameter int BASE   = 'h800,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     bus_strobe,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_data,
    input  logic [PTR_W-1:0]         rd_idx,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic [CYC_W-1:0]         rd_cycle,
    output logic                     rd_valid,
    output logic                     triggered,
    output logic                     frozen,
    output logic [CAT_W-1:0]         err_cat,
    output logic [DATA_W-1:0]        err_value,
    output logic [DATA_W-1:0]        err_index,
    output logic                     err_index_valid,
    output logic [CAT_NUM*CNT_W-1:0] err_counts
);
    localparam int PCW = $clog2(POST + 1);
    localparam logic [PCW-1:0] POST_LAST = PCW'(POST - 1);

    cap_state_e       state, nxt;
    logic [PCW-1:0]   post_cnt;
    logic [CYC_W-1:0] cyc_cnt;
    logic             even_hit, odd_hit, trig, rec_en, armed;
    logic [CAT_W-1:0] hit_cat;

    hs_decoder #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr     (bus_addr),
        .even_hit (even_hit),
        .odd_hit  (odd_hit),
        .cat      (hit_cat)
    );

    assign armed  = (state == ST_ARMED);
    assign trig   = bus_strobe && !clear && armed && even_hit;
    assign rec_en = bus_strobe && !clear && (state != ST_FROZEN);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ARMED;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ARMED:  if (trig) nxt = ST_POST;
            ST_POST:   if (bus_strobe && post_cnt == POST_LAST) nxt = ST_FROZEN;
            ST_FROZEN: nxt = ST_FROZEN;
        endcase
        if (clear) nxt = ST_ARMED;
    end

    // outputs of the state machine
    always_comb begin
        triggered = (state != ST_ARMED);
        frozen    = (state == ST_FROZEN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear || state != ST_POST) post_cnt <= '0;
        else if (bus_strobe)                     post_cnt <= post_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          cyc_cnt <= '0;
        else if (bus_strobe) cyc_cnt <= cyc_cnt + 1'b1;
    end

    hs_ring #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_W(CYC_W), .DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (clear),
        .wr_en    (rec_en),
        .wr_addr  (bus_addr),
        .wr_data  (bus_data),
        .wr_cyc   (cyc_cnt),
        .rd_idx   (rd_idx),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_cyc   (rd_cycle),
        .rd_valid (rd_valid)
    );

    hs_records #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (clear),
        .strobe   (bus_strobe),
        .armed    (armed),
        .trig     (trig),
        .even_hit (even_hit),
        .odd_hit  (odd_hit),
        .hit_cat  (hit_cat),
        .data     (bus_data),
        .cat_q    (err_cat),
        .value_q  (err_value),
        .index_q  (err_index),
        .index_ok (err_index_valid),
        .counts   (err_counts)
    );

    AST_TRIG_FROM_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(triggered) |-> $past(bus_strobe && even_hit && !clear))
        else $error("trigger without value hotspot"); // R4
    AST_FROZEN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !clear) |=> frozen)
        else $error("left frozen without clear"); // R5
    AST_FREEZE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frozen) |-> $past(bus_strobe))
        else $error("froze without strobe"); // R5
    AST_CLEAR_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!triggered && !err_index_valid))
        else $error("clear did not rearm"); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_strobe && !clear) |=> ($stable(triggered) && $stable(frozen) && $stable(err_counts)))
        else $error("state moved without strobe"); // R10
endmodule

// File: tb/hotspot_trace_capture_test.sv
module hotspot_trace_capture_test;
    localparam int DEPTH = 8;
    localparam int POST  = 3;
    localparam int CNT_W = 3;
    localparam int BASE  = 'h800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        bus_strobe = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic [2:0]  rd_idx = '0;
    logic [11:0] rd_addr;
    logic [7:0]  rd_data;
    logic [15:0] rd_cycle;
    logic        rd_valid, triggered, frozen, err_index_valid;
    logic [2:0]  err_cat;
    logic [7:0]  err_value, err_index;
    logic [5*CNT_W-1:0] err_counts;

    hotspot_trace_capture #(.DEPTH(DEPTH), .POST(POST), .CNT_W(CNT_W), .BASE(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .bus_strobe(bus_strobe),
        .bus_addr(bus_addr), .bus_data(bus_data), .rd_idx(rd_idx),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_cycle(rd_cycle), .rd_valid(rd_valid),
        .triggered(triggered), .frozen(frozen), .err_cat(err_cat), .err_value(err_value),
        .err_index(err_index), .err_index_valid(err_index_valid), .err_counts(err_counts)
    );

    always #2.5 clk = ~clk;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;
    int gcyc    = 0;
    int n       = 0;
    bit rec_on  = 0;
    logic [11:0] lg_a [64];
    logic [7:0]  lg_d [64];
    int          lg_c [64];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_strobe = 1'b1;
        @(negedge clk);
        bus_strobe = 1'b0;
        if (rec_on && n < 64) begin
            lg_a[n] = a; lg_d[n] = d; lg_c[n] = gcyc; n++;
        end
        gcyc++;
    endtask

    task automatic do_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        n = 0; rec_on = 1;
    endtask

    task automatic check_trace(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            int src;
            bit ok;
            rd_idx = 3'(i);
            #0.5;
            ok  = (n >= DEPTH) || (i >= DEPTH - n);
            src = (n >= DEPTH) ? (n - DEPTH + i) : (i - (DEPTH - n));
            chk({tag, " R11 valid"}, 32'(rd_valid), 32'(ok));
            if (ok) begin
                chk({tag, " R2 addr"},  32'(rd_addr),  32'(lg_a[src]));
                chk({tag, " R2 data"},  32'(rd_data),  32'(lg_d[src]));
                chk({tag, " R2 cycle"}, 32'(rd_cycle), 32'(lg_c[src] & 16'hFFFF));
            end
        end
    endtask

    function automatic logic [11:0] ev_addr(input int c);
        return 12'(BASE + 16 * c);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 triggered", 32'(triggered), 0);
        chk("R1 frozen", 32'(frozen), 0);
        chk("R1 idx valid", 32'(err_index_valid), 0);
        chk("R1 counts", 32'(err_counts), 0);
        for (int i = 0; i < DEPTH; i++) begin
            rd_idx = 3'(i); #0.5;
            chk("R1 slot valid", 32'(rd_valid), 0);
        end

        // R7 sweep of the whole address space while armed
        rec_on = 0;
        for (int a = 0; a < 4096; a++) begin
            bit skip;
            skip = 0;
            for (int c = 0; c < 5; c++) if (a == BASE + 16 * c) skip = 1;
            if (!skip) begin
                bus_cycle(12'(a), 8'(a));
                chk("R7 no trigger", 32'(triggered), 0);
            end
        end
        chk("R7 no index", 32'(err_index_valid), 0);

        // per-category capture runs
        for (int c = 0; c < 5; c++) begin
            int k;
            k = 2 * c + 1;
            do_clear();
            chk("R9 rearmed", 32'(triggered), 0);
            chk("R9 counts", 32'(err_counts), 0);
            for (int j = 0; j < k; j++) bus_cycle(12'(12'h100 + 16 * c + j), 8'(16 * c + j));
            // R10 hotspot on bus without strobe
            @(negedge clk); bus_addr = ev_addr(c); bus_data = 8'h5A;
            @(negedge clk);
            chk("R10 strobe low", 32'(triggered), 0);
            bus_cycle(ev_addr(c), 8'(8'hA0 + c));
            chk("R4 triggered", 32'(triggered), 1);
            chk("R5 not frozen yet", 32'(frozen), 0);
            chk("R3 R4 category", 32'(err_cat), 32'(c));
            chk("R4 value", 32'(err_value), 32'(8'hA0 + c));
            chk("R6 no index yet", 32'(err_index_valid), 0);
            bus_cycle(ev_addr((c + 1) % 5) + 12'd1, 8'hEE);
            chk("R6 foreign index ignored", 32'(err_index_valid), 0);
            bus_cycle(ev_addr(c) + 12'd1, 8'(8'h30 + c));
            chk("R5 still post", 32'(frozen), 0);
            bus_cycle(ev_addr(c) + 12'd1, 8'h77);
            chk("R5 frozen", 32'(frozen), 1);
            chk("R6 index", 32'(err_index), 32'(8'h30 + c));
            chk("R6 index valid", 32'(err_index_valid), 1);
            rec_on = 0;
            check_trace("R5 window");
            rd_idx = 3'(DEPTH - 1 - POST); #0.5;
            chk("R5 trigger slot", 32'(rd_addr), 32'(ev_addr(c)));
            bus_cycle(12'h123, 8'h99);
            check_trace("R5 held");
        end

        // R8 counting and saturation while frozen
        for (int j = 0; j < 10; j++) bus_cycle(ev_addr(2), 8'(j));
        bus_cycle(ev_addr(4), 8'h11);
        for (int c = 0; c < 5; c++) begin
            int e;
            e = (c == 2) ? 7 : (c == 4) ? 1 : 0;
            chk("R8 counter", 32'(err_counts[c*CNT_W +: CNT_W]), 32'(e));
        end
        chk("R4 value held", 32'(err_value), 32'(8'hA4));
        chk("R4 category held", 32'(err_cat), 4);

        do_clear();
        chk("R9 counts cleared", 32'(err_counts), 0);
        chk("R9 value cleared", 32'(err_value), 0);
        rd_idx = 3'(DEPTH - 1); #0.5;
        chk("R9 R11 slot invalid", 32'(rd_valid), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule